// File: doc/BRIEF.md
# Burst-to-Beat Address Expander

This block accepts one burst command on a valid/ready input: a start address, a burst kind, a beat count minus one and a transfer size given as log2 of bytes per beat. It then produces one address beat for each data transfer on a valid/ready output. Each beat carries its computed address, the burst's kind, length and size fields, and a flag that marks the final beat. A memory-side front end uses it so that a downstream port can deal with single-beat accesses only.

The controller has two states. In `ST_IDLE` the command input is ready and no beat is offered. The transition *accept* (command valid while ready) latches the command, clears the beat counter and the offset, and moves to `ST_EMIT`. In `ST_EMIT` a beat is offered on every cycle. The transition *advance* (beat handshake on a beat that is not final) bumps the counter and the offset and stays in `ST_EMIT`. The transition *finish* (handshake on the final beat) returns to `ST_IDLE`. Three address rules apply: a fixed burst repeats the start address, an incrementing burst steps by 2^size, and a wrapping burst adds a step offset taken modulo 2^size·len.

Top module: `b2b_expander`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `beat_valid` is 0.
- R2: A command with length field L produces exactly L+1 beat handshakes. `beat_last` is 1 on the final one only, and no beat is offered after it.
- R3: Kind 2'b00 (fixed), and the unused code 2'b11, give every beat the start address.
- R4: Kind 2'b01 (incrementing) gives beat i the address start + i·2^size, modulo 2^ADDR_W.
- R5: Kind 2'b10 (wrapping) gives beat i the address start + ((i·2^size) mod (2^size·L)). With L = 0 the single beat carries the start address.
- R6: While `beat_valid` is 1 and `beat_ready` is 0, the next cycle still offers a beat with the same address.
- R7: `cmd_ready` stays 0 from a command's acceptance until its final beat handshake. Commands offered in that window are ignored and do not change the beats. `cmd_ready` is 1 again on the cycle after the final handshake.
- R8: Every beat carries the kind, length and size of the command it came from on `beat_kind`, `beat_len` and `beat_size`.
- R9: `beat_valid` is 1 on the cycle after acceptance, and the first beat's address is the start address. With `beat_ready` held at 1, beats follow on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Burst command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_addr | input | ADDR_W | Burst start address |
| cmd_kind | input | 2 | 00 fixed, 01 incrementing, 10 wrapping, 11 treated as fixed |
| cmd_len | input | LEN_W | Beat count minus one |
| cmd_size | input | SIZE_W | log2 of bytes per beat |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Beat taken by downstream |
| beat_addr | output | ADDR_W | Computed beat address |
| beat_kind | output | 2 | Kind of the current burst |
| beat_len | output | LEN_W | Length field of the current burst |
| beat_size | output | SIZE_W | Size field of the current burst |
| beat_last | output | 1 | Final beat of the burst |

## Verification
The bench applies fixed bursts, including one with the unused kind code, to show that the address never moves. It runs incrementing bursts with several sizes, including one that crosses the top of the address space, to separate a correct step from a missing shift or a dropped carry. Wrapping bursts use a short case whose wrap lands mid-burst and a longer aligned one, which exposes whether the modulus uses L or L+1. Single-beat bursts of every kind and a 256-beat burst under random backpressure test the beat count, the final flag, the hold behaviour and the point at which the command input reopens. One burst keeps a conflicting command on the input while it is busy, to show that the command is ignored.

// File: rtl/b2b_pkg.sv
package b2b_pkg;

    typedef enum logic [1:0] {
        BK_FIXED = 2'b00,
        BK_INCR  = 2'b01,
        BK_WRAP  = 2'b10,
        BK_RSVD  = 2'b11
    } burst_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } b2b_state_e;

endpackage

// File: rtl/b2b_offset_step.sv
module b2b_offset_step
    import b2b_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 3
) (
    input  logic [1:0]        kind,
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] next_offset
);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        step = ADDR_W'(1) << size;
        span = ADDR_W'(len) << size;
        sum  = offset + step;
        case (burst_kind_e'(kind))
            BK_INCR: next_offset = sum;
            BK_WRAP: next_offset = (sum >= span) ? (sum - span) : sum;
            default: next_offset = offset;
        endcase
    end

endmodule

// File: rtl/b2b_beat_track.sv
module b2b_beat_track #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [ADDR_W-1:0] next_offset,
    output logic [LEN_W-1:0]  count,
    output logic [ADDR_W-1:0] offset
);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count  <= '0;
            offset <= '0;
        end else if (advance) begin
            count  <= count + LEN_W'(1);
            offset <= next_offset;
        end
    end

endmodule

// File: rtl/b2b_expander.sv
module b2b_expander
    import b2b_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_kind,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [SIZE_W-1:0] cmd_size,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [1:0]        beat_kind,
    output logic [LEN_W-1:0]  beat_len,
    output logic [SIZE_W-1:0] beat_size,
    output logic              beat_last
);

    b2b_state_e        state_q, state_d;
    logic [ADDR_W-1:0] start_q;
    logic [1:0]        kind_q;
    logic [LEN_W-1:0]  len_q;
    logic [SIZE_W-1:0] size_q;

    logic [LEN_W-1:0]  count;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] next_offset;

    logic accept;
    logic fire;
    logic final_beat;

    assign accept     = cmd_valid && (state_q == ST_IDLE);
    assign fire       = beat_ready && (state_q == ST_EMIT);
    assign final_beat = (count == len_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_EMIT;
            ST_EMIT: if (fire && final_beat) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured burst fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            kind_q  <= BK_FIXED;
            len_q   <= '0;
            size_q  <= '0;
        end else if (accept) begin
            start_q <= cmd_addr;
            kind_q  <= cmd_kind;
            len_q   <= cmd_len;
            size_q  <= cmd_size;
        end
    end

    b2b_offset_step #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .SIZE_W (SIZE_W)
    ) u_step (
        .kind        (kind_q),
        .len         (len_q),
        .size        (size_q),
        .offset      (offset),
        .next_offset (next_offset)
    );

    b2b_beat_track #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (accept),
        .advance     (fire && !final_beat),
        .next_offset (next_offset),
        .count       (count),
        .offset      (offset)
    );

    // outputs
    always_comb begin
        cmd_ready  = 1'b0;
        beat_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: cmd_ready  = 1'b1;
            ST_EMIT: beat_valid = 1'b1;
        endcase
        beat_addr = start_q + offset;
        beat_kind = kind_q;
        beat_len  = len_q;
        beat_size = size_q;
        beat_last = beat_valid && final_beat;
    end

endmodule

// File: rtl/b2b_expander_chk.sv
module b2b_expander_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              beat_valid,
    input logic              beat_ready,
    input logic [ADDR_W-1:0] beat_addr,
    input logic [1:0]        beat_kind,
    input logic [LEN_W-1:0]  beat_len,
    input logic [SIZE_W-1:0] beat_size,
    input logic              beat_last
);

    AST_IDLE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !beat_valid); // R7

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_len))); // R6

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (beat_valid && beat_addr == $past(cmd_addr))); // R9

    AST_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && beat_last) |=> cmd_ready); // R7

    AST_CONTINUE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && !beat_last) |=> (beat_valid && $stable(beat_len))); // R2

    AST_FIXED_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && !beat_last && beat_kind[0] == beat_kind[1])
        |=> $stable(beat_addr)); // R3

    AST_INCR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && !beat_last && beat_kind == 2'b01)
        |=> (beat_addr == $past(beat_addr) + (ADDR_W'(1) << $past(beat_size)))); // R4

endmodule

bind b2b_expander b2b_expander_chk #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .SIZE_W (SIZE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_addr   (cmd_addr),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_addr  (beat_addr),
    .beat_kind  (beat_kind),
    .beat_len   (beat_len),
    .beat_size  (beat_size),
    .beat_last  (beat_last)
);

// File: tb/b2b_expander_test.sv
module b2b_expander_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [1:0]  cmd_kind = '0;
    logic [7:0]  cmd_len = '0;
    logic [2:0]  cmd_size = '0;
    logic        beat_valid;
    logic        beat_ready = 1'b0;
    logic [31:0] beat_addr;
    logic [1:0]  beat_kind;
    logic [7:0]  beat_len;
    logic [2:0]  beat_size;
    logic        beat_last;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    b2b_expander uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_kind(cmd_kind), .cmd_len(cmd_len), .cmd_size(cmd_size),
        .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
        .beat_kind(beat_kind), .beat_len(beat_len), .beat_size(beat_size),
        .beat_last(beat_last)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic longint expect_addr(longint start, int kind, int len, int size, int i);
        longint off;
        case (kind)
            1: off = longint'(i) << size;                                   // R4
            2: off = (len == 0) ? 0 : ((longint'(i) << size) % (longint'(len) << size)); // R5
            default: off = 0;                                               // R3
        endcase
        return (start + off) & 64'hFFFF_FFFF;
    endfunction

    function automatic string kind_req(int kind);
        case (kind)
            1: return "R4";
            2: return "R5";
            default: return "R3";
        endcase
    endfunction

    task automatic run_burst(input logic [31:0] start, input int kind, input int len,
                             input int size, input bit rand_ready, input bit busy_cmd);
        int i = 0;
        int guard = 0;
        bit held = 0;
        logic [31:0] held_addr = '0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_addr  = start;
        cmd_kind  = 2'(kind);
        cmd_len   = 8'(len);
        cmd_size  = 3'(size);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        if (busy_cmd) begin
            cmd_addr = ~start;
            cmd_kind = 2'(kind ^ 1);
            cmd_len  = 8'(len + 3);
            cmd_size = 3'(size + 1);
        end else begin
            cmd_valid = 1'b0;
        end
        check(beat_valid == 1'b1, "R9", beat_valid, 1);
        check(beat_addr == start, "R9", beat_addr, start);
        while (i <= len && guard < 5000) begin
            guard++;
            beat_ready = rand_ready ? lfsr[0] : 1'b1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            #1;
            if (held) check(beat_valid && beat_addr == held_addr, "R6", beat_addr, held_addr);
            check(cmd_ready == 1'b0, "R7", cmd_ready, 0);
            if (beat_valid && beat_ready) begin
                check(beat_addr == 32'(expect_addr(start, kind, len, size, i)), kind_req(kind),
                      beat_addr, expect_addr(start, kind, len, size, i));
                check(beat_last == (i == len), "R2", beat_last, (i == len));
                if (i == 0)
                    check(beat_kind == 2'(kind) && beat_len == 8'(len) && beat_size == 3'(size),
                          "R8", {beat_kind, beat_len, beat_size}, {2'(kind), 8'(len), 3'(size)});
                i++;
                held = 0;
            end else begin
                held = beat_valid;
                held_addr = beat_addr;
            end
            @(negedge clk);
        end
        check(guard < 5000, "R2", guard, len + 1);
        cmd_valid  = 1'b0;
        beat_ready = 1'b0;
        check(beat_valid == 1'b0, "R2", beat_valid, 0);
        check(cmd_ready == 1'b1, "R7", cmd_ready, 1);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(cmd_ready == 1'b1, "R1", cmd_ready, 1);
        check(beat_valid == 1'b0, "R1", beat_valid, 0);
    endtask

    task automatic test_fixed();
        run_burst(32'h1234_5678, 0, 5, 2, 1'b0, 1'b0);   // R3
        run_burst(32'h0000_00F0, 3, 3, 1, 1'b1, 1'b0);   // R3 unused code
    endtask

    task automatic test_incr();
        run_burst(32'h0000_1000, 1, 7, 2, 1'b0, 1'b0);   // R4, R9 back-to-back
        run_burst(32'hFFFF_FFF0, 1, 9, 3, 1'b1, 1'b0);   // R4 address wrap-around
        run_burst(32'h0000_0040, 1, 4, 0, 1'b1, 1'b0);
    endtask

    task automatic test_wrap();
        run_burst(32'h0000_0004, 2, 3, 1, 1'b0, 1'b0);   // R5: 4,6,8,4
        run_burst(32'h0000_0100, 2, 7, 2, 1'b1, 1'b0);   // R5
    endtask

    task automatic test_single();
        for (int k = 0; k < 3; k++) run_burst(32'hA000_0000 + 32'(k), k, 0, 2, 1'b0, 1'b0); // R2, R5
    endtask

    task automatic test_long_busy();
        run_burst(32'h0002_0000, 1, 255, 2, 1'b1, 1'b1); // R2, R6, R7
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_fixed();
        test_incr();
        test_wrap();
        test_single();
        test_long_busy();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule